// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block turns a clock into two enable strobes for serial shifters. The first stage divides a selected source rate by a 16-bit programmable value and produces `sample_tick`, the bit-sample enable. The second stage counts sample ticks and produces `baud_tick` once every (second divisor + 1) sample ticks. The resulting bit rate is source / ((second divisor + 1) × first divisor). For example, a first divisor of 62 and a second divisor of 6 give one baud tick every 434 source enables.

The source is either the undivided clock, with an enable on every cycle, or one enable every 8 clocks. Software-side logic loads the two divisors and the source select through single-cycle write strobes. A first divisor of zero turns the generator off. A second-divisor write below 4 is dropped.

A three-state controller sequences the counters. `ST_LOAD` is entered on reset and on every accepted write. It holds the counters at zero for one cycle. From `ST_LOAD` the controller moves to `ST_OFF` when the first divisor is zero, and to `ST_RUN` otherwise. `ST_OFF` and `ST_RUN` stay where they are until an accepted write sends them back to `ST_LOAD`.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both ticks are low. The first divisor resets to 651 (0x28B), the second divisor resets to 15 and the source is the undivided clock, so sample ticks come every 651 clocks and baud ticks every 10416 clocks.
- R2: With the undivided source and a first divisor N ≥ 2, `sample_tick` is a one-cycle pulse every N clocks.
- R3: `baud_tick` is high only in a cycle where `sample_tick` is also high. It occurs once every (M + 1) sample ticks for a second divisor M, including M = 4 and M = 255.
- R4: While the first divisor is 0, neither tick is ever produced.
- R5: A second-divisor write with a value of 0 to 3 is ignored. The previous value is kept and the counters are not restarted.
- R6: With the source-select bit at 1, the source gives one enable every 8 clocks, so sample ticks come every 8·N clocks.
- R7: An accepted write (first divisor, second divisor ≥ 4, or source select) clears all counters. Both ticks are low in the two cycles after the write. With the undivided source and first divisor N, the first sample tick appears N + 1 cycles after the write cycle.
- R8: A first divisor of 1 with the undivided source holds `sample_tick` high on every cycle of `ST_RUN`. `baud_tick` then comes every M + 1 clocks.
- R9: A first divisor of 62 and a second divisor of 6 with the undivided source give a baud tick every 434 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sample_div | input | 1 | Load strobe for the first-stage divisor |
| sample_div_in | input | 16 | New first-stage divisor |
| wr_baud_div | input | 1 | Load strobe for the second-stage divisor |
| baud_div_in | input | 8 | New second-stage divisor (values below 4 are ignored) |
| wr_clk_sel | input | 1 | Load strobe for the source select |
| clk_sel_in | input | 1 | Source select: 0 undivided clock, 1 one enable per 8 clocks |
| sample_tick | output | 1 | One-cycle bit-sample enable |
| baud_tick | output | 1 | One-cycle baud enable, coincident with a sample tick |

## Verification
The bench targets the terminal-count edges:
- A first divisor of 1. An off-by-one compare would either never fire or fire only every other cycle.
- The second divisor at its minimum legal value of 4 and at its maximum of 255. An off-by-one compare there would stretch or shorten every baud period by one sample tick.

Dropped second-divisor writes of 3 are followed by a period measurement. A design that latched them, or restarted on them, would show a shortened or displaced baud period.

Divisor and source writes issued in mid-count are checked against a behavioural model. A generator that kept stale counts, or let a tick escape in the write or load cycle, would diverge from the model on the exact cycle where the restart should take hold.

// File: rtl/bg_pkg.sv
package bg_pkg;
    localparam int SDIV_W   = 16;
    localparam int BDIV_W   = 8;
    localparam int PRE_W    = 3;
    localparam int BDIV_MIN = 4;
    localparam int SDIV_RST = 'h28B;
    localparam int BDIV_RST = 15;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_OFF  = 2'd1,
        ST_RUN  = 2'd2
    } bg_state_e;
endpackage

// File: rtl/bg_ctrl.sv
module bg_ctrl
    import bg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sdiv_zero,
    output logic run
);
    bg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_LOAD: state_d = sdiv_zero ? ST_OFF : ST_RUN;
                ST_OFF:  state_d = ST_OFF;
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_LOAD;
            endcase
        end
    end

    always_comb begin
        run = (state_q == ST_RUN);
    end
endmodule

// File: rtl/bg_prescale.sv
module bg_prescale #(
    parameter int PRE_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic slow,
    output logic src_en
);
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (run)      cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        src_en = run && (!slow || (cnt_q == PRE_LAST));
    end
endmodule

// File: rtl/bg_divider.sv
module bg_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] term,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    always_comb begin
        hit = en && (cnt_q == term);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (en)       cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import bg_pkg::*;
#(
    parameter int SDIV_WIDTH = SDIV_W,
    parameter int BDIV_WIDTH = BDIV_W,
    parameter int PRE_WIDTH  = PRE_W,
    parameter int BDIV_LOW   = BDIV_MIN,
    parameter int SDIV_INIT  = SDIV_RST,
    parameter int BDIV_INIT  = BDIV_RST
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_sample_div,
    input  logic [SDIV_WIDTH-1:0] sample_div_in,
    input  logic                  wr_baud_div,
    input  logic [BDIV_WIDTH-1:0] baud_div_in,
    input  logic                  wr_clk_sel,
    input  logic                  clk_sel_in,
    output logic                  sample_tick,
    output logic                  baud_tick
);
    localparam logic [BDIV_WIDTH-1:0] BDIV_FLOOR = BDIV_WIDTH'(BDIV_LOW);
    localparam logic [SDIV_WIDTH-1:0] SDIV_ONE   = SDIV_WIDTH'(1);

    logic [SDIV_WIDTH-1:0] sdiv_q;
    logic [BDIV_WIDTH-1:0] bdiv_q;
    logic                  csel_q;
    logic                  bdiv_ok;
    logic                  restart;
    logic                  run;
    logic                  src_en;
    logic                  s_hit;
    logic                  b_hit;

    always_comb begin
        bdiv_ok = wr_baud_div && (baud_div_in >= BDIV_FLOOR);
        restart = wr_sample_div || bdiv_ok || wr_clk_sel;
    end

    // divisor and source-select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdiv_q <= SDIV_WIDTH'(SDIV_INIT);
            bdiv_q <= BDIV_WIDTH'(BDIV_INIT);
            csel_q <= 1'b0;
        end else begin
            if (wr_sample_div) sdiv_q <= sample_div_in;
            if (bdiv_ok)       bdiv_q <= baud_div_in;
            if (wr_clk_sel)    csel_q <= clk_sel_in;
        end
    end

    bg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .sdiv_zero (sdiv_q == '0),
        .run       (run)
    );

    bg_prescale #(.PRE_W(PRE_WIDTH)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .run    (run),
        .slow   (csel_q),
        .src_en (src_en)
    );

    bg_divider #(.W(SDIV_WIDTH)) u_stage1 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .en    (src_en),
        .term  (sdiv_q - SDIV_ONE),
        .hit   (s_hit)
    );

    bg_divider #(.W(BDIV_WIDTH)) u_stage2 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .en    (s_hit),
        .term  (bdiv_q),
        .hit   (b_hit)
    );

    // registered strobes, suppressed in the write cycle
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sample_tick <= 1'b0;
            baud_tick   <= 1'b0;
        end else begin
            sample_tick <= s_hit;
            baud_tick   <= b_hit;
        end
    end
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
    parameter int SW = 16,
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          restart,
    input logic [SW-1:0] sdiv_q,
    input logic [BW-1:0] bdiv_q,
    input logic          wr_baud_div,
    input logic [BW-1:0] baud_div_in,
    input logic          sample_tick,
    input logic          baud_tick
);
    // R3
    baud_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> sample_tick);

    // R2
    sample_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && sdiv_q > SW'(1)) |=> !sample_tick);

    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdiv_q == '0 && $past(sdiv_q) == '0) |-> (!sample_tick && !baud_tick));

    // R5
    low_write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_baud_div && baud_div_in < BW'(4)) |=> $stable(bdiv_q));

    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> (!sample_tick && !baud_tick));

    // R7
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart, 2) |-> (!sample_tick && !baud_tick));
endmodule

bind baud_tick_gen bg_checker #(.SW(SDIV_WIDTH), .BW(BDIV_WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .sdiv_q      (sdiv_q),
    .bdiv_q      (bdiv_q),
    .wr_baud_div (wr_baud_div),
    .baud_div_in (baud_div_in),
    .sample_tick (sample_tick),
    .baud_tick   (baud_tick)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_sample_div = 1'b0;
    logic [15:0] sample_div_in = '0;
    logic        wr_baud_div = 1'b0;
    logic [7:0]  baud_div_in = '0;
    logic        wr_clk_sel = 1'b0;
    logic        clk_sel_in = 1'b0;
    logic        sample_tick;
    logic        baud_tick;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_sample_div (wr_sample_div),
        .sample_div_in (sample_div_in),
        .wr_baud_div   (wr_baud_div),
        .baud_div_in   (baud_div_in),
        .wr_clk_sel    (wr_clk_sel),
        .clk_sel_in    (clk_sel_in),
        .sample_tick   (sample_tick),
        .baud_tick     (baud_tick)
    );

    // behavioural reference: phase 0 load, 1 off, 2 run
    int m_sdiv, m_bdiv, m_csel, m_phase, m_pre, m_s, m_b;
    bit m_st, m_bt;

    always @(posedge clk) begin
        bit acc, src, hs, hb;
        acc = wr_sample_div || (wr_baud_div && baud_div_in >= 4) || wr_clk_sel;
        if (!rst_n) begin
            m_sdiv = 651; m_bdiv = 15; m_csel = 0; m_phase = 0;
            m_pre = 0; m_s = 0; m_b = 0; m_st = 0; m_bt = 0;
        end else if (acc) begin
            if (wr_sample_div) m_sdiv = sample_div_in;
            if (wr_baud_div && baud_div_in >= 4) m_bdiv = baud_div_in;
            if (wr_clk_sel) m_csel = clk_sel_in;
            m_phase = 0; m_pre = 0; m_s = 0; m_b = 0; m_st = 0; m_bt = 0;
        end else if (m_phase == 0) begin
            m_phase = (m_sdiv == 0) ? 1 : 2;
            m_st = 0; m_bt = 0;
        end else if (m_phase == 1) begin
            m_st = 0; m_bt = 0;
        end else begin
            src = (m_csel == 0) || (m_pre == 7);
            m_pre = (m_pre + 1) % 8;
            hs = src && (m_s == m_sdiv - 1);
            if (src) m_s = hs ? 0 : m_s + 1;
            hb = hs && (m_b == m_bdiv);
            if (hs) m_b = hb ? 0 : m_b + 1;
            m_st = hs; m_bt = hb;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(sample_tick === m_st, "R2 sample_tick vs model", sample_tick, m_st);
            chk(baud_tick === m_bt, "R3 baud_tick vs model", baud_tick, m_bt);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick_gap(input bit use_baud, output int g);
        int n;
        n = 0;
        do begin @(negedge clk); n++; end
        while (!(use_baud ? baud_tick : sample_tick) && n < 30000);
        g = 0;
        do begin @(negedge clk); g++; end
        while (!(use_baud ? baud_tick : sample_tick) && g < 30000);
    endtask

    task automatic wr_s(input int v);
        @(negedge clk); wr_sample_div = 1'b1; sample_div_in = 16'(v);
        @(negedge clk); wr_sample_div = 1'b0;
    endtask

    task automatic wr_b(input int v);
        @(negedge clk); wr_baud_div = 1'b1; baud_div_in = 8'(v);
        @(negedge clk); wr_baud_div = 1'b0;
    endtask

    task automatic wr_c(input bit v);
        @(negedge clk); wr_clk_sel = 1'b1; clk_sel_in = v;
        @(negedge clk); wr_clk_sel = 1'b0;
    endtask

    initial begin
        int g;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sample_tick == 0 && baud_tick == 0, "R1 reset ticks low", {sample_tick, baud_tick}, 0);
        tick_gap(1'b0, g); chk(g == 651, "R1 reset sample period", g, 651);
        tick_gap(1'b1, g); chk(g == 10416, "R1 reset baud period", g, 10416);

        wr_s(10); wr_b(4);
        tick_gap(1'b0, g); chk(g == 10, "R2 sample period N=10", g, 10);
        tick_gap(1'b1, g); chk(g == 50, "R3 baud period M=4", g, 50);
        wr_b(3);
        tick_gap(1'b1, g); chk(g == 50, "R5 write of 3 ignored", g, 50);
        wr_b(0);
        tick_gap(1'b1, g); chk(g == 50, "R5 write of 0 ignored", g, 50);
        wr_b(255);
        tick_gap(1'b1, g); chk(g == 2560, "R3 baud period M=255", g, 2560);

        wr_c(1'b1); wr_s(5); wr_b(4);
        tick_gap(1'b0, g); chk(g == 40, "R6 slow source sample period", g, 40);
        tick_gap(1'b1, g); chk(g == 200, "R6 slow source baud period", g, 200);

        wr_s(0);
        cnt = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (sample_tick || baud_tick) cnt++;
        end
        chk(cnt == 0, "R4 no ticks when divisor zero", cnt, 0);

        wr_c(1'b0); wr_b(4);
        @(negedge clk); wr_sample_div = 1'b1; sample_div_in = 16'd7;
        @(negedge clk); wr_sample_div = 1'b0;
        g = 0;
        while (!sample_tick && g < 100) begin @(negedge clk); g++; end
        chk(g == 8, "R7 first tick after restart", g, 8);

        wr_s(1);
        repeat (3) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (sample_tick) cnt++;
            @(negedge clk);
        end
        chk(cnt == 20, "R8 divisor 1 holds sample high", cnt, 20);
        tick_gap(1'b1, g); chk(g == 5, "R8 divisor 1 baud period", g, 5);

        wr_s(62); wr_b(6);
        tick_gap(1'b0, g); chk(g == 62, "R9 sample period 62", g, 62);
        tick_gap(1'b1, g); chk(g == 434, "R9 baud period 434", g, 434);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule